// File: doc/BRIEF.md
# Flash Program-and-Poll Sequencer

This block is a host-side master that burns a run of bytes into a byte-wide parallel flash. For every byte it sends the four-write program command, then reads the target address until the flash reports completion or an error. It then reads the byte once more, because the low data bits can settle later than the status bit, and compares the whole byte against what was written. On success it moves to the next address. On the first failure it stops, raises a fail flag and holds the address that failed.

There are two ways to detect completion, chosen per run. In data-bit mode, bit 7 of a read is compared with bit 7 of the written byte. In toggle mode, bit 6 is compared across two back-to-back reads. In both modes bit 5 is treated as an error hint that must be confirmed by further reads. A poll-count limit ends a byte that shows neither completion nor the error hint.

Bytes come in on a valid/ready stream. The block takes one byte per address, and only while it is about to program; holding the source's valid low stalls it indefinitely. The flash side is a request/acknowledge bus. A request (`bus_valid` with address, write flag and write data) stays fixed until `bus_ready` is high in the same cycle. Read data is taken in that cycle. Flash bus timing is generated outside the block.

Top module: `flash_prog_poller`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `bus_valid` and `in_ready` are all low.
- R2: Each byte is programmed with four bus writes in this order: 0xAA to `UNLOCK_A` (0x555), 0x55 to `UNLOCK_B` (0x2AA), 0xA0 to `UNLOCK_A`, then the byte to its target address.
- R3: Every status and final read uses the target address of the byte being programmed.
- R4: In data-bit mode a read whose bit 7 equals written bit 7 means completion. A mismatch with bit 5 clear means poll again. A mismatch with bit 5 set triggers one confirming read, which passes only if bit 7 then matches.
- R5: In toggle mode reads are taken in pairs. Equal bit 6 in both reads of a pair means completion. Unequal bit 6 with bit 5 of the second read clear means poll again.
- R6: In toggle mode, unequal bit 6 with bit 5 of the second read set triggers two more reads. The byte fails if bit 6 still differs between them.
- R7: After completion a final read of the target address must return the full written byte, otherwise the byte fails.
- R8: If `POLL_LIMIT` consecutive polls (single reads in data-bit mode, read pairs in toggle mode) all ask to poll again, the byte fails with no further reads.
- R9: A run programs `length` consecutive addresses starting at `base_addr`, consuming one stream byte per address, then raises `done` with `fail` low. A run with `length` of 0 ends with `done` and no bus traffic.
- R10: On the first failing byte the block stops all bus traffic, raises both `done` and `fail`, and holds that byte's address on `fail_addr` until the next start.
- R11: `in_ready` is high only while no bus request is pending. `start` has no effect while `busy` is high.
- R12: While `bus_valid` is high and `bus_ready` is low, the request's address, data and write flag stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled when idle) |
| toggle_mode | input | 1 | 1: toggle-bit completion, 0: data-bit completion |
| base_addr | input | AW | First target address |
| length | input | LW | Number of bytes in the run |
| in_valid | input | 1 | Stream byte available |
| in_ready | output | 1 | Block accepts a stream byte |
| in_data | input | 8 | Stream byte |
| bus_valid | output | 1 | Flash bus request pending |
| bus_ready | input | 1 | Flash bus accepts the request this cycle |
| bus_write | output | 1 | 1: write, 0: read |
| bus_addr | output | AW | Request address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with `bus_ready` on a read |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run has ended (held until next start) |
| fail | output | 1 | Last run ended on a failure |
| fail_addr | output | AW | Address of the failing byte |

## Verification
A behavioural flash in the bench answers each byte with a scripted outcome. Clean completion is swept over both modes and every busy length from zero to six reads. Error hints are run two ways, one later cleared and one that persists. A flash that never finishes is also scripted, as are low bits that settle only after a short or a very long lag. The sweeps show that the block finishes at the right read and not before. The error scripts separate a confirmed error from a transient one. The lag scripts show that a stale final read is caught. In the timeout script, the exact read count shows whether polls are counted per read or per pair. Bus and stream stalls, a zero-length run and a start pulse in mid-run check that the request holds steady and that a restart is refused.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  localparam logic [7:0] CMD_KEY1 = 8'hAA;
  localparam logic [7:0] CMD_KEY2 = 8'h55;
  localparam logic [7:0] CMD_PROG = 8'hA0;
  localparam int DONE_BIT = 7;
  localparam int TOG_BIT  = 6;
  localparam int ERR_BIT  = 5;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_CMD, ST_POLL_A, ST_POLL_B,
    ST_CHK_A, ST_CHK_B, ST_FINAL
  } state_t;

  typedef enum logic [2:0] {
    VD_AGAIN, VD_NEXT, VD_PASS, VD_FAIL, VD_CONFIRM
  } verdict_t;
endpackage

// File: rtl/flash_poll_judge.sv
module flash_poll_judge
  import flash_poll_pkg::*;
(
  input  logic       toggle_mode,
  input  state_t     st,
  input  logic [7:0] rd,
  input  logic [7:0] prev,
  input  logic [7:0] wbyte,
  output verdict_t   vd
);
  logic bit_match, tog_same;
  assign bit_match = (rd[DONE_BIT] == wbyte[DONE_BIT]);
  assign tog_same  = (rd[TOG_BIT] == prev[TOG_BIT]);

  always_comb begin
    vd = VD_AGAIN;
    case (st)
      ST_FINAL:  vd = (rd == wbyte) ? VD_PASS : VD_FAIL;
      ST_POLL_A: begin
        if (toggle_mode)    vd = VD_NEXT;
        else if (bit_match) vd = VD_PASS;
        else if (rd[ERR_BIT]) vd = VD_CONFIRM;
        else                vd = VD_AGAIN;
      end
      ST_POLL_B: begin
        if (tog_same)         vd = VD_PASS;
        else if (rd[ERR_BIT]) vd = VD_CONFIRM;
        else                  vd = VD_AGAIN;
      end
      ST_CHK_A: begin
        if (toggle_mode) vd = VD_NEXT;
        else             vd = bit_match ? VD_PASS : VD_FAIL;
      end
      ST_CHK_B: vd = tog_same ? VD_PASS : VD_FAIL;
      default:  vd = VD_AGAIN;
    endcase
  end
endmodule

// File: rtl/flash_poll_limit.sv
module flash_poll_limit #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/flash_addr_walker.sv
module flash_addr_walker #(
  parameter int AW = 19,
  parameter int LW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  output logic [AW-1:0] addr,
  output logic          last
);
  logic [LW-1:0] rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      rem  <= '0;
    end else if (load) begin
      addr <= base;
      rem  <= len;
    end else if (step) begin
      addr <= addr + 1'b1;
      rem  <= rem - 1'b1;
    end
  end

  assign last = (rem == LW'(1));
endmodule

// File: rtl/flash_prog_poller.sv
module flash_prog_poller
  import flash_poll_pkg::*;
#(
  parameter int AW = 19,
  parameter int LW = 20,
  parameter int POLL_LIMIT = 64,
  parameter logic [AW-1:0] UNLOCK_A = AW'('h555),
  parameter logic [AW-1:0] UNLOCK_B = AW'('h2AA)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          toggle_mode,
  input  logic [AW-1:0] base_addr,
  input  logic [LW-1:0] length,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr
);
  state_t        st;
  verdict_t      vd;
  logic [7:0]    wbyte, prev;
  logic [1:0]    step;
  logic          mode_q, done_q, fail_q;
  logic [AW-1:0] fail_addr_q, tgt;
  logic          last, hit;
  logic          rd_state, rd_fire, wk_load, wk_step, lim_inc;

  assign rd_state = (st == ST_POLL_A) || (st == ST_POLL_B) || (st == ST_CHK_A) ||
                    (st == ST_CHK_B)  || (st == ST_FINAL);
  assign rd_fire  = rd_state && bus_ready;
  assign wk_load  = (st == ST_IDLE) && start;
  assign wk_step  = rd_fire && (st == ST_FINAL) && (vd == VD_PASS) && !last;
  assign lim_inc  = rd_fire && (vd == VD_AGAIN) && !hit;

  flash_addr_walker #(.AW(AW), .LW(LW)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(wk_load), .step(wk_step),
    .base(base_addr), .len(length), .addr(tgt), .last(last)
  );

  flash_poll_limit #(.LIMIT(POLL_LIMIT)) u_lim (
    .clk(clk), .rst_n(rst_n), .clr(st == ST_CMD), .inc(lim_inc), .hit(hit)
  );

  flash_poll_judge u_judge (
    .toggle_mode(mode_q), .st(st), .rd(bus_rdata), .prev(prev),
    .wbyte(wbyte), .vd(vd)
  );

  always_comb begin
    bus_valid = (st == ST_CMD) || rd_state;
    bus_write = (st == ST_CMD);
    bus_addr  = tgt;
    bus_wdata = '0;
    if (st == ST_CMD) begin
      case (step)
        2'd0: begin bus_addr = UNLOCK_A; bus_wdata = CMD_KEY1; end
        2'd1: begin bus_addr = UNLOCK_B; bus_wdata = CMD_KEY2; end
        2'd2: begin bus_addr = UNLOCK_A; bus_wdata = CMD_PROG; end
        default: begin bus_addr = tgt;   bus_wdata = wbyte;    end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      wbyte       <= '0;
      prev        <= '0;
      step        <= '0;
      mode_q      <= 1'b0;
      done_q      <= 1'b0;
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          mode_q <= toggle_mode;
          fail_q <= 1'b0;
          if (length == '0) done_q <= 1'b1;
          else begin
            done_q <= 1'b0;
            st     <= ST_FETCH;
          end
        end
        ST_FETCH: if (in_valid) begin
          wbyte <= in_data;
          step  <= '0;
          st    <= ST_CMD;
        end
        ST_CMD: if (bus_ready) begin
          step <= step + 1'b1;
          if (step == 2'd3) st <= ST_POLL_A;
        end
        default: if (bus_ready) begin
          prev <= bus_rdata;
          case (vd)
            VD_NEXT:    st <= (st == ST_CHK_A) ? ST_CHK_B : ST_POLL_B;
            VD_CONFIRM: st <= ST_CHK_A;
            VD_PASS: begin
              if (st != ST_FINAL) st <= ST_FINAL;
              else if (last) begin
                st     <= ST_IDLE;
                done_q <= 1'b1;
              end else st <= ST_FETCH;
            end
            VD_AGAIN: begin
              if (hit) begin
                st          <= ST_IDLE;
                done_q      <= 1'b1;
                fail_q      <= 1'b1;
                fail_addr_q <= tgt;
              end else st <= ST_POLL_A;
            end
            default: begin
              st          <= ST_IDLE;
              done_q      <= 1'b1;
              fail_q      <= 1'b1;
              fail_addr_q <= tgt;
            end
          endcase
        end
      endcase
    end
  end

  assign in_ready  = (st == ST_FETCH);
  assign busy      = (st != ST_IDLE);
  assign done      = done_q;
  assign fail      = fail_q;
  assign fail_addr = fail_addr_q;
endmodule

// File: rtl/flash_prog_poller_chk.sv
module flash_prog_poller_chk #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic          in_ready,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic          bus_write,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata,
  input logic [AW-1:0] fail_addr
);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) &&
                                $stable(bus_wdata) && $stable(bus_write));
  // R10
  quiet_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_valid && !in_ready && !busy);
  // R10
  fail_flags_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);
  // R10
  fail_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail && $past(fail) |-> $stable(fail_addr));
  // R11
  stream_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !bus_valid);
  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && $past(busy) |-> $past(!bus_valid || bus_ready));
endmodule

bind flash_prog_poller flash_prog_poller_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fail(fail),
  .in_ready(in_ready), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .fail_addr(fail_addr)
);

// File: tb/flash_prog_poller_bench.sv
`timescale 1ns/1ps
module flash_prog_poller_bench;
  localparam int AW = 19;
  localparam int LW = 20;
  localparam int LIM = 8;
  localparam int K_OK = 0, K_ERRPASS = 1, K_ERRFAIL = 2, K_HANG = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, toggle_mode = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [LW-1:0] length = '0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic bus_valid, bus_ready = 1'b0, bus_write;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata = '0;
  logic busy, done, fail;
  logic [AW-1:0] fail_addr;

  always #2.5 clk = ~clk;

  flash_prog_poller #(.AW(AW), .LW(LW), .POLL_LIMIT(LIM)) u_flash_prog_poller (
    .clk(clk), .rst_n(rst_n), .start(start), .toggle_mode(toggle_mode),
    .base_addr(base_addr), .length(length), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .done(done),
    .fail(fail), .fail_addr(fail_addr)
  );

  int n_cmp = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scenario tables and flash model state
  logic [7:0] bytes [0:15];
  int kind [0:15], nbusy [0:15], lagn [0:15];
  logic [AW-1:0] exp_base = '0;
  int len_cur = 0, idx = 0, pb = 0, wstep = 0, writes = 0, rd_cnt = 0;
  int busy_left = 0, err_left = 0, lag_left = 0, cur_kind = 0, cyc = 0;
  bit pend_in = 0, stall_en = 0, tog = 0, was_stalled = 0;
  logic [AW-1:0] tgt = '0, s_addr = '0;
  logic [7:0] wcur = '0, s_wdata = '0;
  logic s_write = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (was_stalled) begin
      // R12
      chk(bus_valid && bus_addr == s_addr && bus_wdata == s_wdata && bus_write == s_write,
          "R12 stalled request changed", int'(bus_addr), int'(s_addr));
    end
    bus_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
    if (pend_in) idx++;
    in_valid = (idx < len_cur) && (cyc % 4 != 1);
    in_data  = bytes[idx % 16];
    pend_in  = in_valid && in_ready;
    was_stalled = bus_valid && !bus_ready;
    s_addr = bus_addr; s_wdata = bus_wdata; s_write = bus_write;
    if (bus_valid && bus_ready) begin
      if (bus_write) begin
        logic [AW-1:0] ea;
        logic [7:0] ed;
        case (wstep)
          0: begin ea = AW'('h555); ed = 8'hAA; end
          1: begin ea = AW'('h2AA); ed = 8'h55; end
          2: begin ea = AW'('h555); ed = 8'hA0; end
          default: begin ea = exp_base + AW'(pb); ed = bytes[pb]; end
        endcase
        // R2
        chk(bus_addr == ea && bus_wdata == ed, "R2 command write",
            int'({bus_addr, bus_wdata}), int'({ea, ed}));
        writes++;
        if (wstep == 3) begin
          tgt = bus_addr; wcur = bus_wdata; cur_kind = kind[pb];
          busy_left = nbusy[pb]; err_left = (kind[pb] == K_ERRPASS) ? 1 : 0;
          lag_left = lagn[pb]; rd_cnt = 0; pb++;
        end
        wstep = (wstep + 1) % 4;
      end else begin
        // R3
        chk(bus_addr == tgt, "R3 read address", int'(bus_addr), int'(tgt));
        rd_cnt++;
        if (busy_left > 0 || cur_kind == K_ERRFAIL || cur_kind == K_HANG || err_left > 0) begin
          logic ef;
          ef = (busy_left == 0) && (cur_kind == K_ERRFAIL || err_left > 0);
          if (busy_left > 0) busy_left--;
          else if (err_left > 0) err_left--;
          bus_rdata = {~wcur[7], tog, ef, 5'h0A};
          tog = ~tog;
        end else if (lag_left > 0) begin
          lag_left--;
          bus_rdata = {wcur[7:5], wcur[4:0] ^ 5'h1F};
        end else bus_rdata = wcur;
      end
    end
  end

  task automatic run(input bit tmode, input logic [AW-1:0] base, input int len,
                     input bit glitch, input string tag);
    int fj = -1;
    int nprog;
    for (int j = 0; j < len; j++)
      if (fj < 0 && (kind[j] >= K_ERRFAIL || lagn[j] >= 2)) fj = j;
    @(negedge clk);
    exp_base = base; len_cur = len; idx = 0; pb = 0; wstep = 0; writes = 0;
    toggle_mode = tmode; base_addr = base; length = LW'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (glitch) begin
      repeat (10) @(negedge clk);
      base_addr = base + 19'd100; start = 1'b1;
      @(negedge clk);
      start = 1'b0; base_addr = base;
    end
    for (int w = 0; w < 20000 && !done; w++) @(negedge clk);
    nprog = (fj < 0) ? len : fj + 1;
    chk(done == 1'b1, {tag, " R9 done"}, int'(done), 1);
    chk(fail == (fj >= 0), {tag, " R10 fail flag"}, int'(fail), int'(fj >= 0));
    if (fj >= 0)
      chk(fail_addr == base + AW'(fj), {tag, " R10 fail_addr"}, int'(fail_addr),
          int'(base + AW'(fj)));
    chk(writes == 4 * nprog, {tag, " R10/R9 write count"}, writes, 4 * nprog);
    chk(pb == nprog, {tag, " R9 bytes programmed"}, pb, nprog);
    if (fj >= 0 && kind[fj] == K_HANG) begin
      // R8
      chk(rd_cnt == (tmode ? 2 * LIM : LIM), {tag, " R8 poll limit reads"}, rd_cnt,
          tmode ? 2 * LIM : LIM);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic setup(input int k, input int nb, input int lg);
    for (int j = 0; j < 16; j++) begin
      bytes[j] = 8'(j * 53 + 17 + k * 29 + nb * 7);
      kind[j] = K_OK; nbusy[j] = nb; lagn[j] = lg;
    end
  endtask

  initial begin
    int wd;
    wd = 0;
    fork
      begin
        while (wd < 150000) begin @(negedge clk); wd++; end
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=%0d expected=<150000", wd);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    join_none
    setup(0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!busy && !done && !fail && !bus_valid && !in_ready, "R1 reset state",
        int'({busy, done, fail, bus_valid, in_ready}), 0);

    // R4 R5 sweep: both modes, busy length 0..6, lag 0/1
    for (int m = 0; m < 2; m++)
      for (int nb = 0; nb <= 6; nb++) begin
        setup(m, nb, nb % 2);
        stall_en = (nb % 3 == 1);
        run(m[0], AW'(32'h1000 + nb * 16), 3, 1'b0, m ? "R5 toggle sweep" : "R4 data sweep");
      end
    stall_en = 1'b1;

    // R4 transient error then confirmed pass; persistent error fails
    setup(1, 2, 1); kind[0] = K_ERRPASS; kind[2] = K_ERRFAIL;
    run(1'b0, AW'('h2000), 5, 1'b0, "R4 data error");
    // R6 toggle error paths
    setup(2, 3, 0); kind[1] = K_ERRPASS; kind[3] = K_ERRFAIL;
    run(1'b1, AW'('h3000), 5, 1'b0, "R6 toggle error");
    // R8 hang in both modes
    setup(3, 1, 0); kind[1] = K_HANG;
    run(1'b0, AW'('h4000), 4, 1'b0, "R8 data hang");
    setup(4, 1, 0); kind[2] = K_HANG;
    run(1'b1, AW'('h4100), 4, 1'b0, "R8 toggle hang");
    // R7 stale low bits
    setup(5, 2, 1); lagn[3] = 100;
    run(1'b0, AW'('h5000), 6, 1'b0, "R7 data lag");
    setup(6, 2, 0); lagn[1] = 100;
    run(1'b1, AW'('h5100), 4, 1'b0, "R7 toggle lag");
    // R9 zero length
    setup(7, 0, 0);
    run(1'b0, AW'('h6000), 0, 1'b0, "R9 empty run");
    // R11 start ignored while busy
    setup(8, 4, 1);
    run(1'b1, AW'('h7000), 8, 1'b1, "R11 restart ignored");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule